// File: doc/BRIEF.md
# Key-Match Counter and Tag Comparator

This block produces one match flag per port. Each port holds a tag, and its flag is high whenever that tag equals a shared key word. A small mode register picks the source of the key word. In direct mode the five key lines pass straight through as the key. In counter mode the key comes from an internal up counter that wraps at a programmable terminal count. In that mode the five key lines take new jobs as controls: counter clock, clock enable, synchronous zero, asynchronous clear, and a force-to-all-ones override.

The block runs on one system clock. A rising edge on the counter clock line is found by sampling that line on the system clock. The asynchronous clear does not wait for any clock. The force line only changes what is presented as the key; the count underneath keeps advancing while it is high. A user who drives a clock or enable from a match flag is responsible for qualifying against glitches.

Top module: `key_match_unit`

## Requirements
- R1: For every port i, `matchOut[i]` is 1 exactly when the tag at `portTags[i*5 +: 5]` equals `keyValue`, with no clock delay.
- R2: While the counter-enable mode bit is 0, `keyValue` equals `keyIn` combinationally, and the count does not change whatever the key lines do.
- R3: When `cfgWrEn` is high at a clock edge, `cfgWrData[5]` is stored as the counter-enable bit and `cfgWrData[4:0]` as the terminal count. Both are in effect from the next cycle.
- R4: In counter mode, a counter edge is a system clock edge at which `keyIn[0]` is sampled high after being sampled low at the previous edge. The count grows by one on a counter edge only while `keyIn[1]` is high. Otherwise it holds.
- R5: On a counting edge, a count equal to the terminal value becomes 0. With a terminal of 0 the count stays 0. A count above the terminal keeps rising and wraps from 31 to 0.
- R6: In counter mode, while `keyIn[4]` is high, `keyValue` reads 5'h1F, and the hidden count keeps advancing on counting edges.
- R7: In counter mode, `keyIn[2]` high at a counter edge sets the count to 0, whatever the level of `keyIn[1]`. It takes priority over counting. Without a counter edge it has no effect.
- R8: In counter mode, `keyIn[3]` high sets the count to 0 at once, without waiting for a clock edge. It takes priority over the synchronous zero and over counting.
- R9: Reset (`rstN` low) clears the counter-enable bit, the terminal count and the count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| keyIn | input | 5 | Key lines; counter controls in counter mode |
| cfgWrEn | input | 1 | Mode register write strobe |
| cfgWrData | input | 6 | {counter enable, terminal count[4:0]} |
| portTags | input | NUM_PORTS*5 | Packed per-port tags, port i at bits i*5+4..i*5 |
| matchOut | output | NUM_PORTS | Per-port match flags |
| keyValue | output | 5 | Key word currently compared |

## Verification
Several rules are checked on every cycle by properties. These are the per-port equality, key pass-through in direct mode, the forced all-ones key, a count held at zero under clear, an increment on each counting edge, wrap at the terminal, and a count that holds without an edge. Other behaviour can only be shown by the bench's scenarios. That covers wrap sequences for terminals 5, 0 and 31, and a count above a lowered terminal running on toward 31. It also covers the count returning after the force is released, a clear raised and dropped between two clock edges, and a mode switch that leaves the count untouched.

// File: rtl/km_pkg.sv
package km_pkg;
  localparam int KEY_W = 5;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic useCount;
    logic advance;
    logic syncZero;
    logic forceOnes;
    logic asyncClr;
  } cntCtl_t;
endpackage

// File: rtl/km_key_ctrl.sv
module km_key_ctrl
  import km_pkg::*;
#(
  parameter int KW = KEY_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [KW-1:0] keyIn,
  input  logic          cfgWrEn,
  input  logic [KW:0]   cfgWrData,
  output cntCtl_t       ctl,
  output logic [KW-1:0] termCnt
);
  // fixed roles of the key lines in counter mode
  localparam int ROLE_CLK = 0;
  localparam int ROLE_CKE = 1;
  localparam int ROLE_ZERO = 2;
  localparam int ROLE_CLR = 3;
  localparam int ROLE_ONES = 4;

  logic modeEn;
  logic clkPrev;
  logic cntEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeEn  <= 1'b0;
      termCnt <= '0;
    end else if (cfgWrEn) begin
      modeEn  <= cfgWrData[KW];
      termCnt <= cfgWrData[KW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkPrev <= 1'b0;
    else       clkPrev <= keyIn[ROLE_CLK];
  end

  assign cntEdge = keyIn[ROLE_CLK] & ~clkPrev;

  always_comb begin
    ctl.useCount  = modeEn;
    ctl.asyncClr  = modeEn & keyIn[ROLE_CLR];
    ctl.syncZero  = modeEn & cntEdge & keyIn[ROLE_ZERO];
    ctl.advance   = modeEn & cntEdge & keyIn[ROLE_CKE] & ~keyIn[ROLE_ZERO];
    ctl.forceOnes = modeEn & keyIn[ROLE_ONES];
  end
endmodule

// File: rtl/km_counter.sv
module km_counter
  import km_pkg::*;
#(
  parameter int KW = KEY_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  cntCtl_t       ctl,
  input  logic [KW-1:0] termCnt,
  input  logic [KW-1:0] keyIn,
  output logic [KW-1:0] countVal,
  output logic [KW-1:0] keyValue
);
  logic cntRstN;
  logic [KW-1:0] nextCnt;

  assign cntRstN = rstN & ~ctl.asyncClr;
  assign nextCnt = (countVal == termCnt) ? '0 : countVal + 1'b1;

  always_ff @(posedge clk or negedge cntRstN) begin
    if (!cntRstN)          countVal <= '0;
    else if (ctl.syncZero) countVal <= '0;
    else if (ctl.advance)  countVal <= nextCnt;
  end

  always_comb begin
    if (!ctl.useCount)      keyValue = keyIn;
    else if (ctl.forceOnes) keyValue = '1;
    else                    keyValue = countVal;
  end
endmodule

// File: rtl/km_tag_cmp.sv
module km_tag_cmp
  import km_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int KW = KEY_W
) (
  input  logic [NUM_PORTS*KW-1:0] portTags,
  input  logic [KW-1:0]           keyValue,
  output logic [NUM_PORTS-1:0]    matchOut
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign matchOut[p] = (portTags[p*KW +: KW] == keyValue);
  end
endmodule

// File: rtl/key_match_unit.sv
module key_match_unit
  import km_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int KW = KEY_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [KW-1:0]           keyIn,
  input  logic                    cfgWrEn,
  input  logic [KW:0]             cfgWrData,
  input  logic [NUM_PORTS*KW-1:0] portTags,
  output logic [NUM_PORTS-1:0]    matchOut,
  output logic [KW-1:0]           keyValue
);
  cntCtl_t       ctl;
  logic [KW-1:0] termCnt;
  logic [KW-1:0] countVal;

  km_key_ctrl #(.KW(KW)) u_ctrl (
    .clk(clk), .rstN(rstN), .keyIn(keyIn), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .ctl(ctl), .termCnt(termCnt)
  );

  km_counter #(.KW(KW)) u_cnt (
    .clk(clk), .rstN(rstN), .ctl(ctl), .termCnt(termCnt), .keyIn(keyIn),
    .countVal(countVal), .keyValue(keyValue)
  );

  km_tag_cmp #(.NUM_PORTS(NUM_PORTS), .KW(KW)) u_cmp (
    .portTags(portTags), .keyValue(keyValue), .matchOut(matchOut)
  );
endmodule

// File: rtl/key_match_unit_chk.sv
module key_match_unit_chk
  import km_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int KW = KEY_W
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [KW-1:0]           keyIn,
  input logic [NUM_PORTS*KW-1:0] portTags,
  input logic [NUM_PORTS-1:0]    matchOut,
  input logic [KW-1:0]           keyValue,
  input cntCtl_t                 ctl,
  input logic [KW-1:0]           termCnt,
  input logic [KW-1:0]           countVal
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    // R1
    tag_match_chk: assert property (@(posedge clk) disable iff (!rstN)
      matchOut[p] == (portTags[p*KW +: KW] == keyValue));
  end

  // R2
  direct_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.useCount |-> keyValue == keyIn);

  // R6
  force_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.useCount && keyIn[4]) |-> keyValue == '1);

  // R8
  async_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.useCount && keyIn[3]) |-> countVal == '0);

  // R5
  term_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && countVal == termCnt) |=> countVal == '0);

  // R4
  step_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && countVal != termCnt) |=>
      (countVal == KW'($past(countVal) + 1'b1)) || countVal == '0);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.advance && !ctl.syncZero) |=> ($stable(countVal) || countVal == '0));
endmodule

bind key_match_unit key_match_unit_chk #(.NUM_PORTS(NUM_PORTS), .KW(KW)) u_chk (
  .clk(clk), .rstN(rstN), .keyIn(keyIn), .portTags(portTags),
  .matchOut(matchOut), .keyValue(keyValue), .ctl(ctl),
  .termCnt(termCnt), .countVal(countVal)
);

// File: tb/key_match_unit_test.sv
module key_match_unit_test;
  localparam int NP = 4;
  localparam int KW = 5;

  logic            clk = 1'b0;
  logic            rstN;
  logic [KW-1:0]   keyIn;
  logic            cfgWrEn;
  logic [KW:0]     cfgWrData;
  logic [NP*KW-1:0] portTags;
  logic [NP-1:0]   matchOut;
  logic [KW-1:0]   keyValue;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  key_match_unit #(.NUM_PORTS(NP), .KW(KW)) uut (
    .clk(clk), .rstN(rstN), .keyIn(keyIn), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .portTags(portTags), .matchOut(matchOut),
    .keyValue(keyValue)
  );

  // direct-mode vectors: {key, expected match for tags 03,0A,1F,0A}
  localparam logic [8:0] VECS [6] = '{
    {5'h03, 4'b0001}, {5'h0A, 4'b1010}, {5'h1F, 4'b0100},
    {5'h00, 4'b0000}, {5'h1E, 4'b0000}, {5'h0B, 4'b0000}
  };

  function automatic logic [NP-1:0] expMatch(input logic [KW-1:0] k);
    for (int i = 0; i < NP; i++) expMatch[i] = (portTags[i*KW +: KW] == k);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeMode(input logic en, input logic [KW-1:0] term);
    cfgWrEn = 1'b1;
    cfgWrData = {en, term};
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // one counter clock pulse; count changes at the posedge inside
  task automatic tick();
    keyIn[0] = 1'b1;
    @(negedge clk);
    keyIn[0] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [KW-1:0] expCnt;
    rstN = 1'b0;
    keyIn = '0;
    cfgWrEn = 1'b0;
    cfgWrData = '0;
    portTags = {5'h0A, 5'h1F, 5'h0A, 5'h03};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9: after reset the block is in direct mode
    keyIn = 5'h0A;
    #2;
    check("R9 direct after reset", keyValue, 5'h0A);

    // R1 R2: vector table
    for (int v = 0; v < 6; v++) begin
      keyIn = VECS[v][8:4];
      #2;
      check("R2 key pass", keyValue, VECS[v][8:4]);
      check("R1 match", matchOut, VECS[v][3:0]);
      @(negedge clk);
    end

    // R9: count starts at zero; R3 write takes effect
    keyIn = '0;
    @(negedge clk);
    writeMode(1'b1, 5'd5);
    #2;
    check("R9 count reset", keyValue, 5'h00);

    // R4 R5: terminal 5 wrap sequence
    keyIn[1] = 1'b1;
    expCnt = '0;
    for (int n = 0; n < 7; n++) begin
      tick();
      expCnt = (expCnt == 5'd5) ? 5'd0 : expCnt + 1'b1;
      check("R5 wrap term 5", keyValue, expCnt);
      check("R1 match counter", matchOut, expMatch(expCnt));
    end

    // R4: enable low holds
    keyIn[1] = 1'b0;
    tick();
    tick();
    check("R4 enable low holds", keyValue, 5'd1);

    // R6: force ones while counting continues
    keyIn[1] = 1'b1;
    keyIn[4] = 1'b1;
    #2;
    check("R6 force ones", keyValue, 5'h1F);
    check("R6 force match", matchOut, 4'b0100);
    @(negedge clk);
    tick();
    tick();
    check("R6 force still ones", keyValue, 5'h1F);
    keyIn[4] = 1'b0;
    #2;
    check("R6 count continued", keyValue, 5'd3);
    @(negedge clk);

    // R7: synchronous zero needs an edge, ignores enable
    keyIn[2] = 1'b1;
    keyIn[1] = 1'b0;
    @(negedge clk);
    check("R7 no edge no zero", keyValue, 5'd3);
    tick();
    check("R7 sync zero", keyValue, 5'd0);
    keyIn[2] = 1'b0;
    keyIn[1] = 1'b1;

    // R5: terminal 0 stays at 0
    writeMode(1'b1, 5'd0);
    for (int n = 0; n < 3; n++) begin
      tick();
      check("R5 term 0", keyValue, 5'd0);
    end

    // R5: terminal 31 full range
    writeMode(1'b1, 5'd31);
    for (int n = 0; n < 31; n++) tick();
    check("R5 reach 31", keyValue, 5'd31);
    tick();
    check("R5 wrap from 31", keyValue, 5'd0);

    // R5: count above lowered terminal keeps rising
    tick();
    tick();
    writeMode(1'b1, 5'd1);
    tick();
    check("R5 above term rises", keyValue, 5'd3);

    // R8: clear raised and dropped between edges
    #4;
    keyIn[3] = 1'b1;
    #2;
    check("R8 immediate clear", keyValue, 5'd0);
    keyIn[3] = 1'b0;
    @(negedge clk);
    check("R8 stays clear", keyValue, 5'd0);

    // R8: clear beats counting and sync zero
    writeMode(1'b1, 5'd7);
    tick();
    tick();
    check("R4 count after clear", keyValue, 5'd2);
    keyIn[3] = 1'b1;
    keyIn[0] = 1'b1;
    @(negedge clk);
    check("R8 clear priority", keyValue, 5'd0);
    keyIn[3] = 1'b0;
    keyIn[0] = 1'b0;
    @(negedge clk);

    // R2 R3: direct mode leaves the count alone
    tick();
    tick();
    writeMode(1'b0, 5'd7);
    keyIn = 5'b00011;
    #2;
    check("R2 direct again", keyValue, 5'b00011);
    @(negedge clk);
    keyIn = 5'b01110;
    @(negedge clk);
    keyIn = 5'b00011;
    @(negedge clk);
    keyIn = '0;
    @(negedge clk);
    writeMode(1'b1, 5'd7);
    #2;
    check("R2 count held", keyValue, 5'd2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule